// File: doc/BRIEF.md
# Interleaved Multi-Bank Memory Controller

This block spreads one flat word address space over several independent storage banks. Each incoming address is cut into a bank index and an in-bank offset. A build-time choice sets which end of the address supplies the bank index. In the interleaved arrangement the least significant bits pick the bank, so neighbouring addresses fall into different banks. In the banked arrangement the most significant bits pick the bank, so each bank holds one contiguous region. Every bank receives the offset, but only the bank that was picked acts on it.

Each bank stands for a storage array with a fixed cycle time. After it accepts an access, the bank stays busy for that many clock cycles and refuses further work. The controller takes a request in any cycle in which its target bank is idle. Accesses to different banks therefore overlap, while a second access to a busy bank is held off through a ready handshake. Reads return their data together with the index of the bank that served them. Responses come back in the order the reads were accepted.

Top module: `interleaved_bank_ctrl`

## Requirements
- R1: While reset is applied and in the first cycles after it, `rsp_valid` is 0 and `req_ready` is 1 for every address.
- R2: With the interleaved map (default), the bank index is `req_addr[BANK_BITS-1:0]` and the in-bank offset is `req_addr[ADDR_W-1:BANK_BITS]`.
- R3: With the banked map, the bank index is `req_addr[ADDR_W-1:ADDR_W-BANK_BITS]` and the offset is the remaining low bits. Two addresses that differ only in their low bits then contend for one bank.
- R4: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. For exactly `CYCLE_TIME` cycles after that edge, `req_ready` is 0 for any address in the same bank, and it returns to 1 in the next cycle.
- R5: A busy bank does not lower `req_ready` for addresses in other banks. With the interleaved map, consecutive addresses are accepted on consecutive edges without a stall while each target bank is idle.
- R6: A request to a busy bank sees `req_ready` at 0 and is accepted on the first edge after that bank's busy window ends.
- R7: A read accepted at edge E gives a one-cycle `rsp_valid` pulse after edge E+`CYCLE_TIME`. That pulse carries the last data written to that address and, on `rsp_bank`, the bank index.
- R8: Read responses leave in the order the reads were accepted, including back-to-back responses from different banks.
- R9: A write (`req_write`=1) produces no response.
- R10: A write changes only the selected bank. A location in another bank, or at another offset, keeps its value.
- R11: When a read response leaves in the same cycle as a write to that same address is accepted, the response carries the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all logic on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flat word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Target bank of `req_addr` is idle |
| rsp_valid | output | 1 | Read response present for one cycle |
| rsp_data | output | DATA_W | Read data |
| rsp_bank | output | BANK_BITS | Bank that served the read |

## Verification
Two events in this block can fall in the same cycle. One is the completion of a read in a bank, seen as a response. The other is the acceptance of a new request into that same bank, which frees up exactly as the response leaves. The bench reads a location and then at once requests a write of new data to it. The write stalls for the full busy window and is accepted in the cycle in which the response is presented. Correctness is judged three ways: the response must still carry the old value, the stall must last exactly `CYCLE_TIME` cycles, and a later read must return the new value.

// File: rtl/ibc_pkg.sv
package ibc_pkg;

  // Which end of the address chooses the bank.
  typedef enum logic {
    BANK_MAP_HIGH = 1'b0,
    BANK_MAP_LOW  = 1'b1
  } bank_map_e;

endpackage

// File: rtl/ibc_addr_split.sv
module ibc_addr_split
  import ibc_pkg::*;
#(
  parameter int        ADDR_W    = 8,
  parameter int        BANK_BITS = 2,
  parameter bank_map_e MAP       = BANK_MAP_LOW,
  localparam int       LOC_W     = ADDR_W - BANK_BITS
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [BANK_BITS-1:0] bank_o,
  output logic [LOC_W-1:0]     loc_o
);

  generate
    if (MAP == BANK_MAP_LOW) begin : g_low
      assign bank_o = addr_i[BANK_BITS-1:0];
      assign loc_o  = addr_i[ADDR_W-1:BANK_BITS];
    end else begin : g_high
      assign bank_o = addr_i[ADDR_W-1:LOC_W];
      assign loc_o  = addr_i[LOC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/ibc_bank.sv
module ibc_bank #(
  parameter int  DATA_W     = 16,
  parameter int  LOC_W      = 6,
  parameter int  CYCLE_TIME = 4,
  localparam int DEPTH      = 1 << LOC_W,
  localparam int CNT_W      = $clog2(CYCLE_TIME + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_i,
  input  logic              wr_i,
  input  logic [LOC_W-1:0]  loc_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              rd_pend_q, rd_pend_d;
  logic [LOC_W-1:0]  loc_q;

  assign busy_o  = (cnt_q != '0);
  assign done_o  = rd_pend_q && (cnt_q == CNT_W'(1));
  assign rdata_o = mem[loc_q];

  // next-state
  always_comb begin
    cnt_d     = cnt_q;
    rd_pend_d = rd_pend_q;
    if (acc_i) begin
      cnt_d     = CNT_W'(CYCLE_TIME);
      rd_pend_d = !wr_i;
    end else begin
      if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
      if (done_o)      rd_pend_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rd_pend_q <= 1'b0;
      loc_q     <= '0;
    end else begin
      cnt_q     <= cnt_d;
      rd_pend_q <= rd_pend_d;
      if (acc_i) loc_q <= loc_i;
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (acc_i && wr_i) mem[loc_i] <= wdata_i;
  end

  // R4: a bank only takes work while idle
  assert_idle_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |-> (cnt_q == '0));

  // R4: an accepted access makes the bank busy next cycle
  assert_busy_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_i |=> busy_o);

  // R9: an accepted write never leads to a completion in the next cycle
  assert_write_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && wr_i) |=> !done_o);

endmodule

// File: rtl/ibc_rsp_mux.sv
module ibc_rsp_mux #(
  parameter int  BANK_BITS = 2,
  parameter int  DATA_W    = 16,
  localparam int N_BANKS   = 1 << BANK_BITS
) (
  input  logic [N_BANKS-1:0]   done_i,
  input  logic [DATA_W-1:0]    rdata_i [N_BANKS],
  output logic                 any_o,
  output logic [DATA_W-1:0]    data_o,
  output logic [BANK_BITS-1:0] idx_o
);

  always_comb begin
    any_o  = 1'b0;
    data_o = '0;
    idx_o  = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (done_i[b]) begin
        any_o  = 1'b1;
        data_o = rdata_i[b];
        idx_o  = BANK_BITS'(b);
      end
    end
  end

endmodule

// File: rtl/interleaved_bank_ctrl.sv
module interleaved_bank_ctrl
  import ibc_pkg::*;
#(
  parameter int        ADDR_W     = 8,
  parameter int        BANK_BITS  = 2,
  parameter int        DATA_W     = 16,
  parameter int        CYCLE_TIME = 4,
  parameter bank_map_e MAP        = BANK_MAP_LOW,
  localparam int       N_BANKS    = 1 << BANK_BITS,
  localparam int       LOC_W      = ADDR_W - BANK_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_data,
  output logic [BANK_BITS-1:0] rsp_bank
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // address split
  logic [BANK_BITS-1:0] req_bank;
  logic [LOC_W-1:0]     req_loc;

  ibc_addr_split #(
    .ADDR_W    (ADDR_W),
    .BANK_BITS (BANK_BITS),
    .MAP       (MAP)
  ) u_split (
    .addr_i (req_addr),
    .bank_o (req_bank),
    .loc_o  (req_loc)
  );

  // banks
  logic [N_BANKS-1:0] busy_vec;
  logic [N_BANKS-1:0] done_vec;
  logic [N_BANKS-1:0] acc_vec;
  logic [DATA_W-1:0]  rdata_arr [N_BANKS];
  logic               accept;

  assign req_ready = !busy_vec[req_bank];
  assign accept    = req_valid && req_ready;

  generate
    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
      assign acc_vec[b] = accept && (req_bank == BANK_BITS'(b));

      ibc_bank #(
        .DATA_W     (DATA_W),
        .LOC_W      (LOC_W),
        .CYCLE_TIME (CYCLE_TIME)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_core_n),
        .acc_i   (acc_vec[b]),
        .wr_i    (req_write),
        .loc_i   (req_loc),
        .wdata_i (req_wdata),
        .busy_o  (busy_vec[b]),
        .done_o  (done_vec[b]),
        .rdata_o (rdata_arr[b])
      );
    end
  endgenerate

  // response select
  logic                 mux_any;
  logic [DATA_W-1:0]    mux_data;
  logic [BANK_BITS-1:0] mux_idx;

  ibc_rsp_mux #(
    .BANK_BITS (BANK_BITS),
    .DATA_W    (DATA_W)
  ) u_rsp_mux (
    .done_i  (done_vec),
    .rdata_i (rdata_arr),
    .any_o   (mux_any),
    .data_o  (mux_data),
    .idx_o   (mux_idx)
  );

  // response register: next-state then flops
  logic                 rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0]    rsp_data_q, rsp_data_d;
  logic [BANK_BITS-1:0] rsp_bank_q, rsp_bank_d;

  always_comb begin
    rsp_valid_d = mux_any;
    rsp_data_d  = rsp_data_q;
    rsp_bank_d  = rsp_bank_q;
    if (mux_any) begin
      rsp_data_d = mux_data;
      rsp_bank_d = mux_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_bank_q  <= '0;
    end else begin
      rsp_valid_q <= rsp_valid_d;
      rsp_data_q  <= rsp_data_d;
      rsp_bank_q  <= rsp_bank_d;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
  assign rsp_bank  = rsp_bank_q;

  // R8: completions of separate banks never collide on the response path
  assert_single_completion_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(done_vec));

  // R6: right after an accept, the same bank is not offered again
  assert_same_bank_stall_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    accept |=> ((req_bank != $past(req_bank)) || !req_ready));

endmodule

// File: tb/interleaved_bank_ctrl_bench.sv
module interleaved_bank_ctrl_bench;
  import ibc_pkg::*;

  localparam int C = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // low-order instance
  logic        lo_valid, lo_wr, lo_ready, lo_rsp_valid;
  logic [7:0]  lo_addr;
  logic [15:0] lo_wdata, lo_rsp_data;
  logic [1:0]  lo_rsp_bank;

  // high-order instance
  logic        hi_valid, hi_wr, hi_ready, hi_rsp_valid;
  logic [7:0]  hi_addr;
  logic [15:0] hi_wdata, hi_rsp_data;
  logic [1:0]  hi_rsp_bank;

  interleaved_bank_ctrl #(.ADDR_W(8), .BANK_BITS(2), .DATA_W(16),
                          .CYCLE_TIME(C), .MAP(BANK_MAP_LOW)) u_interleaved_bank_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(lo_valid), .req_write(lo_wr),
    .req_addr(lo_addr), .req_wdata(lo_wdata), .req_ready(lo_ready),
    .rsp_valid(lo_rsp_valid), .rsp_data(lo_rsp_data), .rsp_bank(lo_rsp_bank));

  interleaved_bank_ctrl #(.ADDR_W(8), .BANK_BITS(2), .DATA_W(16),
                          .CYCLE_TIME(C), .MAP(BANK_MAP_HIGH)) u_interleaved_bank_ctrl_hi (
    .clk(clk), .rst_n(rst_n), .req_valid(hi_valid), .req_write(hi_wr),
    .req_addr(hi_addr), .req_wdata(hi_wdata), .req_ready(hi_ready),
    .rsp_valid(hi_rsp_valid), .rsp_data(hi_rsp_data), .rsp_bank(hi_rsp_bank));

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // reference model and expected-response queue
  logic [15:0] model [256];
  int          q_due  [64];
  logic [15:0] q_data [64];
  logic [1:0]  q_bank [64];
  string       q_tag  [64];
  int q_head = 0;
  int q_tail = 0;
  int reads_issued = 0;
  int rsp_seen = 0;
  bit mon_en = 1'b0;

  always @(negedge clk) begin
    if (mon_en) begin
      if (lo_rsp_valid) begin
        rsp_seen++;
        if (q_head < q_tail) begin
          chk(q_due[q_head] == cyc, {q_tag[q_head], " R8 response cycle"}, cyc, q_due[q_head]);
          chk(lo_rsp_data == q_data[q_head], {q_tag[q_head], " response data"},
              lo_rsp_data, q_data[q_head]);
          chk(lo_rsp_bank == q_bank[q_head], "R7 response bank", lo_rsp_bank, q_bank[q_head]);
          q_head++;
        end else begin
          chk(1'b0, "R9 unexpected response", 1, 0);
        end
      end else if (q_head < q_tail && q_due[q_head] <= cyc) begin
        chk(1'b0, {q_tag[q_head], " missing response"}, 0, 1);
        q_head++;
      end
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic drive_op(input bit wr, input logic [7:0] addr, input logic [15:0] data,
                          input string tag, output int stalls);
    stalls = 0;
    lo_valid = 1'b1; lo_wr = wr; lo_addr = addr; lo_wdata = data;
    #1;
    while (!lo_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    if (wr) begin
      model[addr] = data;
    end else begin
      q_due[q_tail]  = cyc + C;
      q_data[q_tail] = model[addr];
      q_bank[q_tail] = addr[1:0];
      q_tag[q_tail]  = tag;
      q_tail++;
      reads_issued++;
    end
    @(negedge clk);
    lo_valid = 1'b0;
  endtask

  // table: {write, addr, data, expected stalls}
  localparam int NV = 17;
  localparam logic [28:0] VEC [NV] = '{
    {1'b1, 8'h00, 16'hA000, 4'd0},
    {1'b1, 8'h01, 16'hA001, 4'd0},
    {1'b1, 8'h02, 16'hA002, 4'd0},
    {1'b1, 8'h03, 16'hA003, 4'd0},
    {1'b1, 8'h05, 16'hB005, 4'd2},
    {1'b0, 8'h00, 16'h0000, 4'd0},
    {1'b0, 8'h01, 16'h0000, 4'd3},
    {1'b0, 8'h05, 16'h0000, 4'd4},
    {1'b0, 8'h02, 16'h0000, 4'd0},
    {1'b0, 8'h03, 16'h0000, 4'd0},
    {1'b1, 8'h04, 16'hC004, 4'd0},
    {1'b0, 8'h04, 16'h0000, 4'd4},
    {1'b0, 8'h00, 16'h0000, 4'd4},
    {1'b0, 8'h01, 16'h0000, 4'd0},
    {1'b0, 8'h02, 16'h0000, 4'd0},
    {1'b0, 8'h03, 16'h0000, 4'd0},
    {1'b0, 8'h00, 16'h0000, 4'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    int st;
    lo_valid = 1'b0; lo_wr = 1'b0; lo_addr = '0; lo_wdata = '0;
    hi_valid = 1'b0; hi_wr = 1'b0; hi_addr = '0; hi_wdata = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(lo_rsp_valid == 1'b0, "R1 rsp_valid in reset", lo_rsp_valid, 0);
    chk(lo_ready == 1'b1, "R1 ready in reset", lo_ready, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      lo_addr = 8'(a * 65);
      #1;
      chk(lo_ready == 1'b1, "R1 ready after reset", lo_ready, 1);
    end
    chk(hi_rsp_valid == 1'b0 && lo_rsp_valid == 1'b0, "R1 no response after reset",
        {hi_rsp_valid, lo_rsp_valid}, 0);
    mon_en = 1'b1;

    // table walk: R2, R5, R6, R7, R8 (interleaved map)
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      drive_op(VEC[i][28], VEC[i][27:20], VEC[i][19:4], "R7", st);
      chk(st == int'(VEC[i][3:0]), "R2/R5/R6 stall count", st, VEC[i][3:0]);
    end
    repeat (C + 3) @(negedge clk);

    // R4: exact busy window of one bank; R5: neighbour stays ready
    begin
      drive_op(1'b0, 8'h02, 16'h0, "R4", st);
      lo_addr = 8'h02;
      for (int k = 0; k < C; k++) begin
        #1;
        chk(lo_ready == 1'b0, "R4 busy window", lo_ready, 0);
        lo_addr = 8'h03;
        #1;
        chk(lo_ready == 1'b1, "R5 other bank ready", lo_ready, 1);
        lo_addr = 8'h02;
        @(negedge clk);
      end
      #1;
      chk(lo_ready == 1'b1, "R4 ready after window", lo_ready, 1);
    end
    repeat (C + 2) @(negedge clk);

    // R10: writes at same offset in another bank and another offset in same bank
    drive_op(1'b1, 8'h30, 16'h1111, "R10", st);
    drive_op(1'b1, 8'h31, 16'h2222, "R10", st);
    drive_op(1'b1, 8'h34, 16'h3333, "R10", st);
    drive_op(1'b0, 8'h30, 16'h0, "R10", st);
    repeat (C + 2) @(negedge clk);

    // R11: response leaves as a write to the same address is accepted
    drive_op(1'b1, 8'h20, 16'h5A01, "R11", st);
    repeat (C + 2) @(negedge clk);
    drive_op(1'b0, 8'h20, 16'h0, "R11", st);
    drive_op(1'b1, 8'h20, 16'h5A02, "R11", st);
    chk(st == C, "R11 write stall", st, C);
    drive_op(1'b0, 8'h20, 16'h0, "R11", st);
    repeat (C + 3) @(negedge clk);

    // R9: writes generate no responses
    chk(rsp_seen == reads_issued, "R9 response count", rsp_seen, reads_issued);
    chk(q_head == q_tail, "R8 queue drained", q_head, q_tail);

    // R3: banked map on the second instance
    hi_valid = 1'b1; hi_wr = 1'b1; hi_addr = 8'hC5; hi_wdata = 16'h5A5A;
    #1;
    chk(hi_ready == 1'b1, "R3 idle ready", hi_ready, 1);
    @(posedge clk);
    @(negedge clk);
    hi_valid = 1'b0; hi_addr = 8'hC6;
    #1;
    chk(hi_ready == 1'b0, "R3 same top bits stall", hi_ready, 0);
    hi_addr = 8'h05;
    #1;
    chk(hi_ready == 1'b1, "R3 other top bits ready", hi_ready, 1);
    repeat (C + 1) @(negedge clk);
    hi_valid = 1'b1; hi_wr = 1'b0; hi_addr = 8'hC5;
    #1;
    chk(hi_ready == 1'b1, "R3 read ready", hi_ready, 1);
    @(posedge clk);
    @(negedge clk);
    hi_valid = 1'b0;
    repeat (C - 1) @(negedge clk);
    chk(hi_rsp_valid == 1'b0, "R7 no early response", hi_rsp_valid, 0);
    @(negedge clk);
    chk(hi_rsp_valid == 1'b1, "R7 response timing", hi_rsp_valid, 1);
    chk(hi_rsp_bank == 2'd3, "R3 response bank", hi_rsp_bank, 3);
    chk(hi_rsp_data == 16'h5A5A, "R3 response data", hi_rsp_data, 16'h5A5A);
    @(negedge clk);
    chk(hi_rsp_valid == 1'b0, "R7 single-cycle pulse", hi_rsp_valid, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule